// File: doc/BRIEF.md
# Paged Memory Window Bridge

This block lets an 8-bit processor bus reach a 16M-word external memory with 16-bit words. Software first programs a 16-bit page number and an upper data byte through a small group of control registers. It then reads or writes a fixed 256-byte window in the processor's address map. Each window access becomes one request to the memory controller. The request's 24-bit address is the page number with the 8-bit window offset placed below it. A write request carries the stored upper byte above the processor's write byte.

The processor is held with a ready signal for the whole transaction. The request stays asserted and unchanged until the memory controller acknowledges it. On a read, the bridge then waits for the returned 16-bit word. It hands one byte of that word back to the processor, chosen by the lowest address bit, and lowers the stall on the following cycle.

Top module: `pageWindowBridge`

## Requirements
- R1: A synchronous reset clears the page number and the upper data byte to zero, drops any pending request, and leaves `cpuReady` high.
- R2: A control write (`ctrlSel` and `cpuWe` both high) with `cpuAddr[1:0]`=0 loads `cpuWrData` into bits [7:0] of the page number.
- R3: A control write with `cpuAddr[1:0]`=1 loads `cpuWrData` into bits [15:8] of the page number.
- R4: A control write with `cpuAddr[1:0]`=2 loads `cpuWrData` into the stored upper data byte.
- R5: The control registers keep their values unless `ctrlSel` and `cpuWe` are both high at a clock edge. A control read leaves them unchanged, and so does a control write with `cpuAddr[1:0]`=3.
- R6: A window access is `cpuValid` high, `ctrlSel` low and `cpuAddr[15:8]` equal to the window page (default 0xA0). It issues a request with `memAddr` = {page[15:0], cpuAddr[7:0]} and `memWe` = `cpuWe`. An access outside the window raises no request and does not stall.
- R7: A window write sends `memWrData` = {upper data byte, cpuWrData}.
- R8: `memReq` stays high, and `memAddr`, `memWrData` and `memWe` stay unchanged, until the cycle in which `memAck` is high.
- R9: `cpuReady` is low from the cycle a window access is presented until the transaction finishes.
- R10: A window read returns `memRdData[7:0]` when `cpuAddr[0]`=0 and `memRdData[15:8]` when `cpuAddr[0]`=1.
- R11: `cpuReady` rises in the cycle after `memRdValid` for a read, and in the cycle after `memAck` for a write. It stays high for one cycle before the bridge accepts a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuValid | input | 1 | Processor access strobe |
| ctrlSel | input | 1 | Selects the control register group |
| cpuWe | input | 1 | Processor write enable |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 8 | Processor write byte |
| cpuRdData | output | 8 | Byte returned to the processor |
| cpuReady | output | 1 | Low while the processor must wait |
| memReq | output | 1 | Request to the memory controller |
| memWe | output | 1 | Request is a write |
| memAddr | output | 24 | Request word address |
| memWrData | output | 16 | Request write word |
| memAck | input | 1 | Controller accepts the request |
| memRdValid | input | 1 | Read word is valid |
| memRdData | input | 16 | Read word from the controller |

## Verification
Assertions check on every cycle that the request is held with stable fields until it is acknowledged (R8), and that the processor is stalled while a request is pending (R9). They also check that the control registers change only on a control write (R5), and that ready rises the cycle after read data arrives (R11). What only the bench's scenarios can show is the values themselves. These are the concatenated address and write word, the byte lane picked on reads, the decode of each register offset, and the fact that accesses outside the window are ignored. The bench checks these against values it works out from the requirements.

// File: rtl/pageWindowBridge_pkg.sv
package pageWindowBridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_RDWT  = 2'd2,
    ST_DONE  = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic loadReq;    // latch address/data of a new window access
    logic captureRd;  // latch the returned read byte
  } bridgeStrobes_t;
endpackage

// File: rtl/pageWindowBridgeCtrl.sv
module pageWindowBridgeCtrl
  import pageWindowBridge_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           winHit,
  input  logic           isWrite,
  input  logic           memAck,
  input  logic           memRdValid,
  output logic           memReq,
  output logic           cpuReady,
  output bridgeStrobes_t strobes
);
  bridgeState_t state, stateNext;
  logic reqIsWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      reqIsWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.loadReq) reqIsWrite <= isWrite;
    end
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (winHit) begin
        strobes.loadReq = 1'b1;
        stateNext       = ST_REQ;
      end
      ST_REQ: if (memAck) stateNext = reqIsWrite ? ST_DONE : ST_RDWT;
      ST_RDWT: if (memRdValid) begin
        strobes.captureRd = 1'b1;
        stateNext         = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq   = (state == ST_REQ);
  assign cpuReady = ((state == ST_IDLE) && !winHit) || (state == ST_DONE);

  // R11: ready follows returned read data by one cycle
  assert_ready_after_data_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDWT && memRdValid) |=> cpuReady);
  // R8: request persists until acknowledged
  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> memReq);
endmodule

// File: rtl/pageWindowBridgeDp.sv
module pageWindowBridgeDp
  import pageWindowBridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 16,
  parameter int OFFS_W   = 8,
  parameter int BYTE_W   = 8,
  localparam int MADDR_W = PAGE_W + OFFS_W,
  localparam int WORD_W  = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrlWr,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0]  cpuWrData,
  input  logic               cpuWe,
  input  bridgeStrobes_t     strobes,
  input  logic [WORD_W-1:0]  memRdData,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic               memWe,
  output logic [BYTE_W-1:0]  cpuRdData
);
  localparam int PAGE_BYTES = PAGE_W / BYTE_W;

  logic [PAGE_W-1:0] pageReg;
  logic [BYTE_W-1:0] dataHi;
  logic              laneHigh;

  // page register bytes, one per register offset
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_pageByte
    always_ff @(posedge clk) begin
      if (rst) pageReg[b*BYTE_W +: BYTE_W] <= '0;
      else if (ctrlWr && cpuAddr[1:0] == b[1:0])
        pageReg[b*BYTE_W +: BYTE_W] <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataHi    <= '0;
      memAddr   <= '0;
      memWrData <= '0;
      memWe     <= 1'b0;
      laneHigh  <= 1'b0;
      cpuRdData <= '0;
    end else begin
      if (ctrlWr && cpuAddr[1:0] == 2'd2) dataHi <= cpuWrData;
      if (strobes.loadReq) begin
        memAddr   <= {pageReg, cpuAddr[OFFS_W-1:0]};
        memWrData <= {dataHi, cpuWrData};
        memWe     <= cpuWe;
        laneHigh  <= cpuAddr[0];
      end
      if (strobes.captureRd)
        cpuRdData <= laneHigh ? memRdData[WORD_W-1:BYTE_W] : memRdData[BYTE_W-1:0];
    end
  end

  // R5: control state changes only on a control write
  assert_ctrl_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrlWr)) |-> ($stable(pageReg) && $stable(dataHi)));
endmodule

// File: rtl/pageWindowBridge.sv
module pageWindowBridge
  import pageWindowBridge_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PAGE_W   = 16,
  parameter int          OFFS_W   = 8,
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  WIN_PAGE = 8'hA0,
  localparam int         MADDR_W  = PAGE_W + OFFS_W,
  localparam int         WORD_W   = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpuValid,
  input  logic               ctrlSel,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [BYTE_W-1:0]  cpuWrData,
  output logic [BYTE_W-1:0]  cpuRdData,
  output logic               cpuReady,
  output logic               memReq,
  output logic               memWe,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWrData,
  input  logic               memAck,
  input  logic               memRdValid,
  input  logic [WORD_W-1:0]  memRdData
);
  bridgeStrobes_t strobes;
  logic winHit, ctrlWr;

  assign winHit = cpuValid && !ctrlSel && (cpuAddr[ADDR_W-1:OFFS_W] == WIN_PAGE);
  assign ctrlWr = ctrlSel && cpuWe;

  pageWindowBridgeCtrl u_ctrl (
    .clk(clk), .rst(rst), .winHit(winHit), .isWrite(cpuWe),
    .memAck(memAck), .memRdValid(memRdValid),
    .memReq(memReq), .cpuReady(cpuReady), .strobes(strobes)
  );

  pageWindowBridgeDp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .ctrlWr(ctrlWr), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .strobes(strobes), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .cpuRdData(cpuRdData)
  );

  // R9: processor stalled while a request is outstanding
  assert_stall_during_req_R9: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);
  // R8: request fields frozen until acknowledged
  assert_fields_stable_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(memReq) && !$past(memAck) && !$past(rst)) |->
      ($stable(memAddr) && $stable(memWrData) && $stable(memWe)));
endmodule

// File: tb/pageWindowBridge_tb.sv
module pageWindowBridge_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic cpuValid, ctrlSel, cpuWe;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWrData;
  logic [7:0]  cpuRdData;
  logic cpuReady, memReq, memWe;
  logic [23:0] memAddr;
  logic [15:0] memWrData;
  logic memAck, memRdValid;
  logic [15:0] memRdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageWindowBridge u_dut (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .ctrlSel(ctrlSel), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memAck(memAck), .memRdValid(memRdValid), .memRdData(memRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleBus();
    cpuValid = 0; ctrlSel = 0; cpuWe = 0; cpuAddr = '0; cpuWrData = '0;
    memAck = 0; memRdValid = 0; memRdData = '0;
  endtask

  // one-cycle control access; inputs change at negedge
  task automatic ctrlAccess(input logic [1:0] idx, input logic [7:0] val, input bit we);
    @(negedge clk);
    ctrlSel = 1; cpuWe = we; cpuAddr = {14'h0, idx}; cpuWrData = val;
    @(negedge clk);
    ctrlSel = 0; cpuWe = 0;
  endtask

  // window access; controller model acks after ackWait cycles, data after rdWait
  task automatic windowAccess(input logic [7:0] offs, input bit we, input logic [7:0] wd,
                              input int ackWait, input int rdWait, input logic [15:0] rdWord,
                              input logic [23:0] expAddr, input logic [15:0] expWr,
                              input logic [7:0] expRd);
    @(negedge clk);
    cpuValid = 1; cpuWe = we; cpuAddr = {8'hA0, offs}; cpuWrData = wd;
    #1 check(cpuReady == 0, "R9 stall on presentation", cpuReady, 0);
    @(negedge clk);
    check(memReq == 1, "R6 request raised", memReq, 1);
    check(memAddr == expAddr, "R6 address concat", memAddr, expAddr);
    check(memWe == we, "R6 write flag", memWe, we);
    if (we) check(memWrData == expWr, "R7 write word", memWrData, expWr);
    for (int i = 0; i < ackWait; i++) begin
      @(negedge clk);
      check(memReq == 1 && memAddr == expAddr, "R8 request held", memReq, 1);
      check(cpuReady == 0, "R9 stalled while pending", cpuReady, 0);
    end
    memAck = 1;
    @(negedge clk);
    memAck = 0;
    check(memReq == 0, "R8 request dropped after ack", memReq, 0);
    if (!we) begin
      for (int i = 0; i < rdWait; i++) begin
        check(cpuReady == 0, "R9 stalled waiting data", cpuReady, 0);
        @(negedge clk);
      end
      check(cpuReady == 0, "R11 no early ready", cpuReady, 0);
      memRdValid = 1; memRdData = rdWord;
      @(negedge clk);
      memRdValid = 0; memRdData = 16'hDEAD;
      check(cpuReady == 1, "R11 ready after read data", cpuReady, 1);
      check(cpuRdData == expRd, "R10 byte lane", cpuRdData, expRd);
    end else begin
      check(cpuReady == 1, "R11 ready after write ack", cpuReady, 1);
    end
    cpuValid = 0; cpuWe = 0;
    @(negedge clk);
    check(cpuReady == 1 && memReq == 0, "R11 back to idle", cpuReady, 1);
  endtask

  task automatic testReset();
    idleBus(); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(memReq == 0, "R1 no request after reset", memReq, 0);
    check(cpuReady == 1, "R1 ready after reset", cpuReady, 1);
    windowAccess(8'h10, 1, 8'h55, 0, 0, 16'h0, 24'h000010, 16'h0055, 8'h0);
  endtask

  task automatic testCtrlRegs();
    ctrlAccess(2'd0, 8'h34, 1);  // R2
    ctrlAccess(2'd1, 8'h12, 1);  // R3
    ctrlAccess(2'd2, 8'hBE, 1);  // R4
    windowAccess(8'h7F, 1, 8'hEF, 2, 0, 16'h0, 24'h12347F, 16'hBEEF, 8'h0);
    // R5: control read and offset 3 ignored
    ctrlAccess(2'd0, 8'hFF, 0);
    ctrlAccess(2'd3, 8'hFF, 1);
    windowAccess(8'h00, 1, 8'h01, 0, 0, 16'h0, 24'h123400, 16'hBE01, 8'h0);
  endtask

  task automatic testReads();
    windowAccess(8'h02, 0, 8'h0, 1, 2, 16'hA1B2, 24'h123402, 16'h0, 8'hB2);  // R10 even
    windowAccess(8'h03, 0, 8'h0, 0, 0, 16'hC3D4, 24'h123403, 16'h0, 8'hC3);  // R10 odd
  endtask

  task automatic testOutsideWindow();
    @(negedge clk);
    cpuValid = 1; cpuWe = 1; cpuAddr = 16'hA100; cpuWrData = 8'h99;
    #1 check(cpuReady == 1, "R6 no stall outside window", cpuReady, 1);
    @(negedge clk);
    check(memReq == 0, "R6 no request outside window", memReq, 0);
    cpuValid = 0; cpuWe = 0;
  endtask

  task automatic testResetMidRequest();
    @(negedge clk);
    cpuValid = 1; cpuWe = 0; cpuAddr = 16'hA044;
    @(negedge clk);
    check(memReq == 1, "R1 request pending before reset", memReq, 1);
    cpuValid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check(memReq == 0, "R1 reset drops request", memReq, 0);
    windowAccess(8'h01, 1, 8'h22, 0, 0, 16'h0, 24'h000001, 16'h0022, 8'h0);
  endtask

  initial begin
    testReset();
    testCtrlRegs();
    testReads();
    testOutsideWindow();
    testResetMidRequest();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule